// File: doc/BRIEF.md
# Boot Overlay Address Switch

This block decodes CPU bus cycles for a 68k-style system so that the reset vectors can be fetched from ROM. After reset an overlay is active. The ROM image appears at the bottom of the address map, so the first fetches from address 0 return ROM words. Writes that land in that overlaid low region are dropped. The ROM also has a permanent home window, which repeats across a wider range of high addresses. The first read the CPU makes anywhere in that home window retires the overlay for good. From the next bus cycle on, the low addresses select RAM.

On each bus cycle the block returns a registered decision one clock later. The decision is a ROM select with a word index masked to the image size, or a RAM select with a write enable and a word index, or no select at all. The overlaid low region spans the ROM image size or a 4 MB cap, whichever is smaller. Low addresses above that span but inside RAM reach RAM even while the overlay is active. The memories sit outside the block.

Top module: `boot_overlay_switch`

## Requirements
- R1: While reset is high and in the first cycle after it, `overlay_on` is 1 and neither `rom_cs` nor `ram_cs` is asserted.
- R2: With the overlay active, a read at a low address below the overlay span (min of ROM size and 4 MB; 512 KB by default) gives `rom_cs`=1 one cycle later, with `rom_idx` = byte address bits [18:2], so the word index wraps within the image.
- R3: With the overlay active, a write inside the overlay span asserts no select and no write enable, and the overlay stays on.
- R4: A read whose address, with the mirror bits 0x0FF80000 and the image offset bits 0x0007FFFF cleared, equals 0x40000000 gives `rom_cs`=1 with `rom_idx` = address bits [18:2]. This holds for every mirror copy.
- R5: The first read in the ROM window clears the overlay. That read still returns `rom_cs`. `overlay_on` reads 0 from the next cycle, and the next low-address access goes to RAM.
- R6: A write into the ROM window asserts no select and does not clear the overlay.
- R7: With the overlay cleared, an access below the RAM size (8 MB by default) gives `ram_cs`=1 and `ram_idx` = address bits [22:2]. `ram_we` equals the write flag of the access.
- R8: Once cleared, the overlay stays cleared for all later accesses until reset, and a reset sets it again.
- R9: An address that is in neither the ROM window nor the RAM range asserts no select.
- R10: With the overlay active, a low address at or above the overlay span but below the RAM size reaches RAM (`ram_cs`=1, `ram_we` as requested).
- R11: A cycle with `bus_valid` low asserts no select and leaves the overlay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| rom_cs | output | 1 | Registered ROM select |
| rom_idx | output | 17 | Registered ROM word index |
| ram_cs | output | 1 | Registered RAM select |
| ram_we | output | 1 | Registered RAM write enable |
| ram_idx | output | 21 | Registered RAM word index |
| overlay_on | output | 1 | Current overlay state |

## Verification
The bench walks the overlay through its whole life. It reads the vectors, has a write dropped in the overlaid span, and has a write into the ROM window that must not retire the overlay. A design that cleared the overlay on any ROM-window access would send the later low reads to RAM too early. The bench then makes the switching read through a high mirror copy. A design that ignored the mirror bits would leave the overlay on, and one that switched on the same cycle would return RAM for that read. Two further probes cover addresses just above the overlay span and just above the RAM size. These catch an overlay span taken as the 4 MB cap instead of the image size, and a RAM decode that wraps. A final reset shows that the overlay comes back.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2
  } target_e;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rom_window_decode.sv
module rom_window_decode #(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] ROM_BASE    = 32'h4000_0000,
  parameter logic [31:0] MIRROR_MASK = 32'h0FF8_0000,
  parameter int          ROM_AW      = 19
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ROM_AW-3:0] word_idx
);
  localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((64'd1 << ROM_AW) - 1);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(MIRROR_MASK[ADDR_W-1:0] | OFFS_MASK);

  always_comb begin
    hit      = ((addr & KEEP_MASK) == (ROM_BASE[ADDR_W-1:0] & KEEP_MASK));
    word_idx = addr[ROM_AW-1:2];
  end
endmodule

// File: rtl/low_region_decode.sv
module low_region_decode #(
  parameter int ADDR_W = 32,
  parameter int OVL_AW = 19,
  parameter int RAM_AW = 23
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_ovl,
  output logic              in_ram,
  output logic [RAM_AW-3:0] ram_word
);
  generate
    if (OVL_AW < ADDR_W) begin : g_ovl_part
      assign in_ovl = (addr[ADDR_W-1:OVL_AW] == '0);
    end else begin : g_ovl_all
      assign in_ovl = 1'b1;
    end
    if (RAM_AW < ADDR_W) begin : g_ram_part
      assign in_ram = (addr[ADDR_W-1:RAM_AW] == '0);
    end else begin : g_ram_all
      assign in_ram = 1'b1;
    end
  endgenerate
  assign ram_word = addr[RAM_AW-1:2];
endmodule

// File: rtl/overlay_flag.sv
module overlay_flag (
  input  logic clk,
  input  logic rst,
  input  logic clear_req,
  output logic ovl_q
);
  always_ff @(posedge clk) begin
    if (rst)            ovl_q <= 1'b1;
    else if (clear_req) ovl_q <= 1'b0;
  end

  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !ovl_q |=> !ovl_q);
  assert_clear_effect_R5: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> !ovl_q);
endmodule

// File: rtl/boot_overlay_switch.sv
module boot_overlay_switch #(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] ROM_BASE    = 32'h4000_0000,
  parameter logic [31:0] MIRROR_MASK = 32'h0FF8_0000,
  parameter int          ROM_BYTES   = 512 * 1024,
  parameter int          OVL_CAP     = 4 * 1024 * 1024,
  parameter int          RAM_BYTES   = 8 * 1024 * 1024,
  localparam int         ROM_AW      = $clog2(ROM_BYTES),
  localparam int         RAM_AW      = $clog2(RAM_BYTES),
  localparam int         OVL_AW      = $clog2(boot_overlay_pkg::min_u(ROM_BYTES, OVL_CAP))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rom_cs,
  output logic [ROM_AW-3:0] rom_idx,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-3:0] ram_idx,
  output logic              overlay_on
);
  import boot_overlay_pkg::*;

  logic              win_hit, in_ovl, in_ram, clear_req;
  logic [ROM_AW-3:0] win_word;
  logic [RAM_AW-3:0] ram_word;
  target_e           tgt;

  rom_window_decode #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE),
                      .MIRROR_MASK(MIRROR_MASK), .ROM_AW(ROM_AW)) u_win (
    .addr(bus_addr), .hit(win_hit), .word_idx(win_word));

  low_region_decode #(.ADDR_W(ADDR_W), .OVL_AW(OVL_AW), .RAM_AW(RAM_AW)) u_low (
    .addr(bus_addr), .in_ovl(in_ovl), .in_ram(in_ram), .ram_word(ram_word));

  assign clear_req = bus_valid && !bus_wr && win_hit;

  overlay_flag u_flag (.clk(clk), .rst(rst), .clear_req(clear_req), .ovl_q(overlay_on));

  always_comb begin
    tgt = TGT_NONE;
    if (bus_valid) begin
      if (win_hit) begin
        if (!bus_wr) tgt = TGT_ROM;
      end else if (overlay_on && in_ovl) begin
        if (!bus_wr) tgt = TGT_ROM;
      end else if (in_ram) begin
        tgt = TGT_RAM;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs  <= 1'b0;
      ram_cs  <= 1'b0;
      ram_we  <= 1'b0;
      rom_idx <= '0;
      ram_idx <= '0;
    end else begin
      rom_cs  <= (tgt == TGT_ROM);
      ram_cs  <= (tgt == TGT_RAM);
      ram_we  <= (tgt == TGT_RAM) && bus_wr;
      rom_idx <= win_word;
      ram_idx <= ram_word;
    end
  end

  assert_one_select_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, ram_cs}));
  assert_we_needs_cs_R7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_cs);
  assert_block_low_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_wr && overlay_on && in_ovl) |=> (!rom_cs && !ram_cs && overlay_on));
  assert_rom_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_wr && win_hit) |=> (!rom_cs && !ram_cs && $stable(overlay_on)));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!rom_cs && !ram_cs && $stable(overlay_on)));
  assert_switch_read_rom_R5: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> rom_cs);
endmodule

// File: tb/test_boot_overlay_switch.sv
module test_boot_overlay_switch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        rom_cs, ram_cs, ram_we, overlay_on;
  logic [16:0] rom_idx;
  logic [20:0] ram_idx;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  boot_overlay_switch i_boot_overlay_switch (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .rom_cs(rom_cs), .rom_idx(rom_idx), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_idx(ram_idx), .overlay_on(overlay_on));

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic        rom;
    logic        ram;
    logic        we;
    logic [31:0] idx;
    logic        ovl;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0,     1'b1, 8'd2},  // R2
    '{1'b0, 32'h0000_0104, 1'b1, 1'b0, 1'b0, 32'h41,    1'b1, 8'd2},  // R2
    '{1'b1, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'd3},  // R3
    '{1'b0, 32'h0008_0000, 1'b0, 1'b1, 1'b0, 32'h20000, 1'b1, 8'd10}, // R10
    '{1'b1, 32'h0008_0004, 1'b0, 1'b1, 1'b1, 32'h20001, 1'b1, 8'd10}, // R10
    '{1'b0, 32'h5000_0000, 1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'd9},  // R9
    '{1'b0, 32'h0080_0000, 1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'd9},  // R9
    '{1'b1, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 32'h0,     1'b1, 8'd6},  // R6
    '{1'b0, 32'h4FF8_0008, 1'b1, 1'b0, 1'b0, 32'h2,     1'b0, 8'd5},  // R5
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0,     1'b0, 8'd7},  // R7
    '{1'b1, 32'h0000_0010, 1'b0, 1'b1, 1'b1, 32'h4,     1'b0, 8'd7},  // R7
    '{1'b0, 32'h4007_FFFC, 1'b1, 1'b0, 1'b0, 32'h1FFFF, 1'b0, 8'd4},  // R4
    '{1'b0, 32'h4123_4568, 1'b1, 1'b0, 1'b0, 32'hD15A,  1'b0, 8'd4},  // R4
    '{1'b0, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 32'h0,     1'b0, 8'd8}   // R8
  };

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = wr; bus_addr = addr;
    @(posedge clk);
    #2;
    bus_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic rom, input logic ram,
                            input logic we, input logic [31:0] idx, input logic ovl);
    check(tag, "rom_cs", {31'b0, rom_cs}, {31'b0, rom});
    check(tag, "ram_cs", {31'b0, ram_cs}, {31'b0, ram});
    check(tag, "ram_we", {31'b0, ram_we}, {31'b0, we});
    check(tag, "overlay_on", {31'b0, overlay_on}, {31'b0, ovl});
    if (rom) check(tag, "rom_idx", {15'b0, rom_idx}, idx);
    if (ram) check(tag, "ram_idx", {11'b0, ram_idx}, idx);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    expect_out("R1", 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);   // R1 during reset
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    expect_out("R1", 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);   // R1 first cycle after

    access(1'b0, 32'h0007_FFFC);                        // R2 top of overlay span
    expect_out("R2", 1'b1, 1'b0, 1'b0, 32'h1FFFF, 1'b1);

    // R11: idle cycle with a ROM-window address presented but not valid
    @(negedge clk); bus_addr = 32'h4000_0000; bus_wr = 1'b0;
    @(posedge clk); #2;
    expect_out("R11", 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr);
      expect_out($sformatf("R%0d", VEC[i].req), VEC[i].rom, VEC[i].ram, VEC[i].we,
                 VEC[i].idx, VEC[i].ovl);
    end

    // R8: reset brings the overlay back, low reads return ROM again
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R8", "overlay after reset", {31'b0, overlay_on}, 32'h1);
    access(1'b0, 32'h0000_0008);
    expect_out("R8", 1'b1, 1'b0, 1'b0, 32'h2, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule